// File: doc/BRIEF.md
# Synchronous Radio Bit-Clock Data Port

This block sits between a radio modem core and an external microcontroller and owns the serial data exchange between them. It divides the reference oscillator clock down to a bit-rate clock. The division is a 6-bit integer factor times a power-of-two prescale. When synchronous operation is enabled, that clock goes out on the port's data clock pin. Every exchange is tied to its rising edge, and the microcontroller is expected to act on the falling edge.

In transmit, the block captures the user's data line on each rising data-clock edge. It hands the bit to the modulator together with a one-cycle strobe. In receive, it launches the next received bit onto the shared data line at each rising edge and sends a one-cycle request back to the receive path for the following bit. The block drives the shared line only in synchronous receive. With synchronous operation off, the data clock is released and the transmit data passes straight through.

Top module: `radio_data_port`

## Requirements
- R1: While `syncEn` is 0, `dataClkOe` is 0, `dataClk` is held low and no strobe is raised. While `syncEn` is 1, `dataClkOe` is 1.
- R2: With `syncEn` set and the configuration held, `dataClk` has a period of `divK * 2^(7 - prescaleSel)` `clk` cycles. It is high for exactly half of each period and low for the other half.
- R3: A `divK` of 0 acts as 1, and a `prescaleSel` of 7 acts as 6.
- R4: A change of `divK` or `prescaleSel` is taken up only at the next rising `dataClk` edge. The phase in progress completes at the old length.
- R5: In synchronous transmit (`txMode` = 1), `txBit` takes the value `dataIn` had at the `clk` edge where `dataClk` rises, and holds it until the next rise. `txStrobe` is high for exactly the one cycle in which `dataClk` has just risen.
- R6: In synchronous receive (`txMode` = 0), `dataOut` takes the value `rxBit` had at the `clk` edge where `dataClk` rises, and holds it otherwise. `rxReq` is high for exactly the one cycle in which `dataClk` has just risen.
- R7: `dataOe` is 1 only in synchronous receive. It is always 0 in transmit and whenever `syncEn` is 0.
- R8: While `syncEn` is 0, `txBit` follows `dataIn` in the same cycle.
- R9: During reset (synchronous, `rstN` low), `dataClk`, `txStrobe`, `rxReq` and `dataOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncEn | input | 1 | Synchronous operation enable |
| txMode | input | 1 | 1 = transmit, 0 = receive |
| divK | input | 6 | Integer bit-clock divider |
| prescaleSel | input | 3 | Power-of-two prescale select |
| dataIn | input | 1 | Data line value as seen at the pad |
| rxBit | input | 1 | Next received bit from the receive path |
| dataOut | output | 1 | Value driven onto the data line |
| dataOe | output | 1 | Output enable for the data line |
| dataClk | output | 1 | Bit-rate data clock |
| dataClkOe | output | 1 | Output enable for the data clock pin |
| txBit | output | 1 | Bit handed to the modulator |
| txStrobe | output | 1 | One-cycle valid for `txBit` |
| rxReq | output | 1 | One-cycle request for the next receive bit |

## Verification
The bench goes after the divider extremes. A zero divider that was not clamped would stall the clock, and a prescale of 7 that was not clamped would shift the wrong way and give a wrong period. The bench also changes the configuration in the middle of a high phase. A design that picked the change up at once would cut that phase short and emit a runt pulse. It also switches mode and enable in the middle of a period. A design that decoded direction wrongly would drive the data line during transmit, or fire the wrong strobe. Finally, it toggles the data while synchronous operation is off, where a design that sampled through a register would show a one-cycle lag.

// File: rtl/radio_port_pkg.sv
package radio_port_pkg;
  typedef struct packed {
    logic launch;  // rising data-clock edge happens at this clk edge
    logic txSide;  // direction: 1 = transmit
    logic active;  // synchronous operation enabled
  } portCtl_t;
endpackage

// File: rtl/bit_clock_ctrl.sv
module bit_clock_ctrl
  import radio_port_pkg::*;
#(
  parameter int KW   = 6,
  parameter int SW   = 3,
  parameter int MAXS = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncEn,
  input  logic          txMode,
  input  logic [KW-1:0] divK,
  input  logic [SW-1:0] prescaleSel,
  output logic          dataClk,
  output portCtl_t      ctl
);
  localparam int HW = KW + MAXS;

  logic [HW-1:0] halfNew, halfLat, cnt;
  logic [KW-1:0] kEff;
  logic [SW-1:0] sEff;
  logic          phaseEnd;

  always_comb begin
    kEff = (divK == '0) ? KW'(1) : divK;
    sEff = (prescaleSel > SW'(MAXS)) ? SW'(MAXS) : prescaleSel;
    halfNew = HW'(kEff) << (SW'(MAXS) - sEff);
  end

  assign phaseEnd = (cnt == halfLat - HW'(1));

  always_ff @(posedge clk) begin
    if (!rstN || !syncEn) begin
      cnt     <= '0;
      dataClk <= 1'b0;
      halfLat <= halfNew;
    end else if (phaseEnd) begin
      cnt     <= '0;
      dataClk <= ~dataClk;
      if (!dataClk) halfLat <= halfNew;  // new period starts at the rise
    end else begin
      cnt <= cnt + HW'(1);
    end
  end

  always_comb begin
    ctl.active = syncEn;
    ctl.txSide = txMode;
    ctl.launch = rstN && syncEn && phaseEnd && !dataClk;
  end
endmodule

// File: rtl/bit_data_path.sv
module bit_data_path
  import radio_port_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  portCtl_t ctl,
  input  logic     dataIn,
  input  logic     rxBit,
  output logic     txBit,
  output logic     txStrobe,
  output logic     dataOut,
  output logic     dataOe,
  output logic     rxReq
);
  logic txHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHeld   <= 1'b0;
      dataOut  <= 1'b0;
      txStrobe <= 1'b0;
      rxReq    <= 1'b0;
    end else begin
      txStrobe <= ctl.launch && ctl.txSide;
      rxReq    <= ctl.launch && !ctl.txSide;
      if (ctl.launch && ctl.txSide)  txHeld  <= dataIn;
      if (ctl.launch && !ctl.txSide) dataOut <= rxBit;
    end
  end

  assign txBit  = ctl.active ? txHeld : dataIn;
  assign dataOe = ctl.active && !ctl.txSide;
endmodule

// File: rtl/radio_data_port.sv
module radio_data_port
  import radio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncEn,
  input  logic       txMode,
  input  logic [5:0] divK,
  input  logic [2:0] prescaleSel,
  input  logic       dataIn,
  input  logic       rxBit,
  output logic       dataOut,
  output logic       dataOe,
  output logic       dataClk,
  output logic       dataClkOe,
  output logic       txBit,
  output logic       txStrobe,
  output logic       rxReq
);
  portCtl_t ctl;

  bit_clock_ctrl #(.KW(6), .SW(3), .MAXS(6)) uClk (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .txMode(txMode),
    .divK(divK), .prescaleSel(prescaleSel), .dataClk(dataClk), .ctl(ctl)
  );

  bit_data_path uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn), .rxBit(rxBit),
    .txBit(txBit), .txStrobe(txStrobe), .dataOut(dataOut),
    .dataOe(dataOe), .rxReq(rxReq)
  );

  assign dataClkOe = syncEn;
endmodule

// File: rtl/radio_data_port_checker.sv
module radio_data_port_checker (
  input logic clk,
  input logic rstN,
  input logic syncEn,
  input logic txMode,
  input logic dataClk,
  input logic dataOe,
  input logic dataOut,
  input logic txStrobe,
  input logic rxReq
);
  AST_CLK_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN) !syncEn |=> !dataClk); // R1
  AST_TX_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN) txStrobe |-> dataClk && !$past(dataClk)); // R5
  AST_TX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) txStrobe |=> !txStrobe); // R5
  AST_RX_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN) rxReq |=> !rxReq); // R6
  AST_RX_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN) !rxReq |-> $stable(dataOut)); // R6
  AST_NO_DRIVE_IN_TX: assert property (@(posedge clk) disable iff (!rstN) txMode |-> !dataOe); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(txStrobe && rxReq)); // R5
endmodule

bind radio_data_port radio_data_port_checker uChk (
  .clk(clk), .rstN(rstN), .syncEn(syncEn), .txMode(txMode), .dataClk(dataClk),
  .dataOe(dataOe), .dataOut(dataOut), .txStrobe(txStrobe), .rxReq(rxReq)
);

// File: tb/radio_data_port_test.sv
module radio_data_port_test;
  logic clk = 1'b0, rstN = 1'b0, syncEn = 1'b0, txMode = 1'b0;
  logic [5:0] divK = 6'd3;
  logic [2:0] prescaleSel = 3'd6;
  logic dataIn = 1'b0, rxBit = 1'b0;
  logic dataOut, dataOe, dataClk, dataClkOe, txBit, txStrobe, rxReq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  radio_data_port uut (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .txMode(txMode), .divK(divK),
    .prescaleSel(prescaleSel), .dataIn(dataIn), .rxBit(rxBit), .dataOut(dataOut),
    .dataOe(dataOe), .dataClk(dataClk), .dataClkOe(dataClkOe), .txBit(txBit),
    .txStrobe(txStrobe), .rxReq(rxReq)
  );

  function automatic int halfOf(input int k, input int s);
    int ke = (k == 0) ? 1 : k;   // R3
    int se = (s > 6) ? 6 : s;    // R3
    return ke * (1 << (6 - se));
  endfunction

  // Behavioural reference: cycles remaining in the current phase.
  int mLeft = 0, mHalf = 3;
  bit mClk = 0, mTx = 0, mOut = 0, mTs = 0, mRq = 0;
  always @(posedge clk) begin
    mTs = 0; mRq = 0;
    if (!rstN) begin
      mClk = 0; mTx = 0; mOut = 0; mHalf = halfOf(divK, prescaleSel); mLeft = mHalf;
    end else if (!syncEn) begin
      mClk = 0; mHalf = halfOf(divK, prescaleSel); mLeft = mHalf;
    end else begin
      mLeft = mLeft - 1;
      if (mLeft == 0) begin
        if (!mClk) begin
          mHalf = halfOf(divK, prescaleSel);  // R4: taken at the rise
          if (txMode) begin mTx = dataIn; mTs = 1; end
          else begin mOut = rxBit; mRq = 1; end
        end
        mClk = !mClk;
        mLeft = mHalf;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      check("R2", "dataClk", dataClk, mClk);
      check("R1", "dataClkOe", dataClkOe, syncEn);
      check("R7", "dataOe", dataOe, syncEn && !txMode);
      check("R5", "txStrobe", txStrobe, mTs);
      check("R6", "rxReq", rxReq, mRq);
      check(syncEn ? "R5" : "R8", "txBit", txBit, syncEn ? mTx : dataIn);
      check("R6", "dataOut", dataOut, mOut);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic measure(input int k, input int s, input string req);
    int t0;
    divK = 6'(k); prescaleSel = 3'(s);
    @(posedge dataClk); @(posedge dataClk); t0 = cyc;
    @(posedge dataClk);
    check(req, "period", cyc - t0, 2 * halfOf(k, s));
    #1;
  endtask

  initial begin
    #(5ns * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    step(4);
    check("R9", "reset dataClk", dataClk, 0);
    check("R9", "reset strobes", txStrobe | rxReq, 0);
    check("R9", "reset dataOut", dataOut, 0);
    rstN = 1;
    // R8: transparent transmit, R1: clock idle
    txMode = 1;
    for (int i = 0; i < 20; i++) begin dataIn = $urandom_range(0, 1); step(1); end
    // R5: synchronous transmit
    syncEn = 1;
    for (int i = 0; i < 120; i++) begin dataIn = $urandom_range(0, 1); step(1); end
    // R6: synchronous receive
    txMode = 0;
    for (int i = 0; i < 120; i++) begin rxBit = $urandom_range(0, 1); step(1); end
    // R2 / R3 periods
    measure(5, 6, "R2");
    measure(1, 0, "R2");
    measure(63, 4, "R2");
    measure(0, 7, "R3");
    measure(0, 6, "R3");
    measure(2, 7, "R3");
    // R4: change config while high; reference model verifies phase lengths
    divK = 6'd4; prescaleSel = 3'd5; step(40);
    @(posedge dataClk); #1; step(2);
    divK = 6'd1; prescaleSel = 3'd6;
    step(40);
    // Random mode, enable and config churn
    for (int i = 0; i < 4000; i++) begin
      dataIn = $urandom_range(0, 1);
      rxBit = $urandom_range(0, 1);
      if ($urandom_range(0, 60) == 0) txMode = ~txMode;
      if ($urandom_range(0, 150) == 0) syncEn = ~syncEn;
      if ($urandom_range(0, 80) == 0) begin
        divK = 6'($urandom_range(0, 4));
        prescaleSel = 3'($urandom_range(4, 7));
      end
      step(1);
    end
    syncEn = 0; step(3);
    check("R1", "dataClk idle", dataClk, 0);
    finishRun();
  end
endmodule